// File: doc/BRIEF.md
# Smart Shutdown Fault Controller

This block decides when the three phase drivers of a motor inverter must be switched off. It watches three fault sources. The first is an overcurrent comparator flag. The second is the logic level read back from a shared, active-low shutdown pin. The third is an undervoltage flag for the control supply. From these it drives one global disable line to the phase drivers, plus an enable for the open-drain transistor that can pull the shutdown pin low.

An overcurrent event removes drive straight away through a direct path that does not wait for the shutdown pin. At the same time the controller latches the pin pull-down. It keeps that pull-down on until it reads the pin as low, then lets go. From that point the external RC network on the pin decides how long the drivers stay off, because drive returns only once the pin reads high again. The pin level also acts as an ordinary active-low disable input. If the overcurrent is still present when the pin recovers, the controller trips again.

The comparator flag and the pin level arrive asynchronously and pass through a synchroniser of parameterised depth. The undervoltage flag is taken as already synchronous to the clock.

Top module: `ssd_ctrl`

## Requirements
- R1: While reset is active, and in the cycle after a reset taken in the middle of a fault, `pd_en` and `fault_latched` are 0. During reset `drv_off` is 1, because the synchronised pin level starts as "low".
- R2: A rising `oc_trip` sets `drv_off` to 1 exactly SYNC_STAGES clock edges later, which is 2 with the defaults. `drv_off` is still 0 after a single edge.
- R3: One edge after the direct kill, `pd_en` and `fault_latched` both become 1.
- R4: Once `pd_en` is on, it stays on for as long as the synchronised pin reads high, even after `oc_trip` has cleared.
- R5: When the synchronised pin reads low with `pd_en` on, `pd_en` goes to 0 on the next edge and `drv_off` stays 1. The pin level takes SYNC_STAGES edges to become visible.
- R6: After the pull-down is released, `drv_off` and `fault_latched` stay 1 until the synchronised pin reads high. Both then clear on the following edge.
- R7: A low level on `sd_pin_in` with no overcurrent sets `drv_off` after SYNC_STAGES edges. It latches no fault and turns on no pull-down. Drive returns when the pin reads high again.
- R8: `uv_flag` = 1 sets `drv_off` within one edge and clears it within one edge of falling. It latches no fault and turns on no pull-down.
- R9: If `oc_trip` is still 1 when a latched fault clears, `drv_off` never falls, and `pd_en` and `fault_latched` come back on at the next edge.
- R10: From a rising `oc_trip` to `drv_off` = 1, the latency is never more than SYNC_STAGES edges. This is well inside a 250 ns budget at 200 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_trip | input | 1 | Asynchronous overcurrent comparator output, 1 = trip |
| sd_pin_in | input | 1 | Asynchronous level read from the shutdown pin, 0 = shutdown |
| uv_flag | input | 1 | Synchronous control-supply undervoltage, 1 = low supply |
| drv_off | output | 1 | Global disable to all high- and low-side drivers, 1 = off |
| pd_en | output | 1 | Enable for the open-drain pull-down on the shutdown pin |
| fault_latched | output | 1 | A comparator fault is latched (pull-down or hold phase) |

## Verification
The stimulus covers four cases. The first is a lone trip whose comparator clears while the pin is still high. This separates the latched pull-down from the direct kill. The second pulls the pin low from outside with no trip, which shows the pin acting as a plain disable with no latching. The third is an undervoltage pulse, which shows the combinational disable path with no state change. The fourth holds the trip through the whole release, which shows that the controller re-arms into a fresh trip instead of a gap in the drive. Each step is sampled on both sides of the synchroniser delay, so an off-by-one in the kill latency or in the release point shows up as a mismatch.

// File: rtl/ssd_pkg.sv
package ssd_pkg;

    // Fault sequencer phases
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,   // no latched fault
        ST_PULL  = 2'd1,   // pull-down on, waiting for pin to read low
        ST_HOLD  = 2'd2    // pull-down released, waiting for pin to read high
    } ssd_state_e;

    // Synchronised view of the fault sources
    typedef struct packed {
        logic oc;      // overcurrent seen
        logic pin_hi;  // shutdown pin reads high (inactive)
        logic uv;      // undervoltage
    } ssd_sense_s;

    function automatic logic is_latched(input ssd_state_e st);
        return st != ST_ARMED;
    endfunction

endpackage

// File: rtl/ssd_sync.sv
module ssd_sync #(
    parameter int  STAGES  = 2,
    parameter bit  RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ssd_seq.sv
module ssd_seq
    import ssd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ssd_sense_s sense,
    output ssd_state_e state,
    output logic       pull_on
);
    ssd_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_ARMED: if (sense.oc)      state_nxt = ST_PULL;
            ST_PULL:  if (!sense.pin_hi) state_nxt = ST_HOLD;
            ST_HOLD:  if (sense.pin_hi)  state_nxt = ST_ARMED;
            default:                     state_nxt = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_ARMED;
        else     state <= state_nxt;
    end

    assign pull_on = (state == ST_PULL);
endmodule

// File: rtl/ssd_kill.sv
module ssd_kill
    import ssd_pkg::*;
(
    input  ssd_sense_s sense,
    input  ssd_state_e state,
    output logic       kill
);
    // Direct path: a synchronised trip removes drive without waiting for
    // the sequencer or the pin.
    assign kill = sense.oc | ~sense.pin_hi | sense.uv | is_latched(state);
endmodule

// File: rtl/ssd_ctrl.sv
module ssd_ctrl
    import ssd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic oc_trip,
    input  logic sd_pin_in,
    input  logic uv_flag,
    output logic drv_off,
    output logic pd_en,
    output logic fault_latched
);
    ssd_sense_s sense;
    ssd_state_e state;
    logic       oc_s;
    logic       pin_s;

    ssd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_oc (
        .clk(clk), .rst(rst), .d(oc_trip), .q(oc_s)
    );

    // Pin starts as "low" so drive stays off until it is seen high
    ssd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pin (
        .clk(clk), .rst(rst), .d(sd_pin_in), .q(pin_s)
    );

    assign sense = '{oc: oc_s, pin_hi: pin_s, uv: uv_flag};

    ssd_seq u_seq (
        .clk(clk), .rst(rst), .sense(sense), .state(state), .pull_on(pd_en)
    );

    ssd_kill u_kill (
        .sense(sense), .state(state), .kill(drv_off)
    );

    assign fault_latched = is_latched(state);
endmodule

// File: rtl/ssd_ctrl_chk.sv
module ssd_ctrl_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst,
    input logic oc_trip,
    input logic pin_s,
    input logic drv_off,
    input logic pd_en,
    input logic fault_latched
);
    localparam int CW = $clog2(SYNC_STAGES + 4);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [CW-1:0] wait_cnt;

    // Counts edges with a trip pending and drive still on
    always_ff @(posedge clk) begin
        if (rst)                            wait_cnt <= '0;
        else if (oc_trip && !drv_off) begin
            if (wait_cnt != CMAX)           wait_cnt <= wait_cnt + 1'b1;
        end else                            wait_cnt <= '0;
    end

    assert_kill_latency_R10: assert property (@(posedge clk) disable iff (rst)
        wait_cnt <= CW'(SYNC_STAGES));

    assert_pull_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_en) |-> drv_off && $past(drv_off));

    assert_pull_hold_R4: assert property (@(posedge clk) disable iff (rst)
        pd_en && pin_s |=> pd_en);

    assert_pull_release_R5: assert property (@(posedge clk) disable iff (rst)
        pd_en && !pin_s |=> !pd_en && drv_off);

    assert_clear_on_pin_high_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_latched) |-> $past(pin_s));
endmodule

bind ssd_ctrl ssd_ctrl_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk(clk), .rst(rst), .oc_trip(oc_trip), .pin_s(pin_s),
    .drv_off(drv_off), .pd_en(pd_en), .fault_latched(fault_latched)
);

// File: tb/test_ssd_ctrl.sv
`timescale 1ns/1ps
module test_ssd_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic oc_trip = 1'b0;
    logic sd_pin_in = 1'b1;
    logic uv_flag = 1'b0;
    logic drv_off, pd_en, fault_latched;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ssd_ctrl #(.SYNC_STAGES(2)) i_ssd_ctrl (
        .clk(clk), .rst(rst), .oc_trip(oc_trip), .sd_pin_in(sd_pin_in),
        .uv_flag(uv_flag), .drv_off(drv_off), .pd_en(pd_en),
        .fault_latched(fault_latched)
    );

    // Vector: [13]oc [12]pin [11]uv [10:7]edges [6]drv_off [5]pd_en [4]fault [3:0]req
    localparam int NV = 22;
    localparam logic [13:0] VECS [NV] = '{
        14'b0_1_0_0011_0_0_0_0001, // R1 idle, drive on
        14'b1_1_0_0001_0_0_0_0010, // R2 one edge: not yet through sync
        14'b1_1_0_0001_1_0_0_0010, // R2 kill after second edge
        14'b1_1_0_0001_1_1_1_0011, // R3 pull-down and latch
        14'b0_1_0_0100_1_1_1_0100, // R4 trip gone, pin high: pull held
        14'b0_0_0_0001_1_1_1_0101, // R5 pin low not yet synced
        14'b0_0_0_0001_1_1_1_0101, // R5 synced, sequencer moves next edge
        14'b0_0_0_0001_1_0_1_0101, // R5 pull released, drive still off
        14'b0_0_0_0011_1_0_1_0110, // R6 hold while pin low
        14'b0_1_0_0001_1_0_1_0110, // R6 pin high not yet synced
        14'b0_1_0_0001_1_0_1_0110, // R6 synced, still latched
        14'b0_1_0_0001_0_0_0_0110, // R6 cleared
        14'b0_0_0_0010_1_0_0_0111, // R7 external pin low
        14'b0_0_0_0011_1_0_0_0111, // R7 no latch while low
        14'b0_1_0_0010_0_0_0_0111, // R7 drive back
        14'b0_1_1_0001_1_0_0_1000, // R8 undervoltage
        14'b0_1_0_0001_0_0_0_1000, // R8 recovers
        14'b1_1_0_0011_1_1_1_1001, // R9 trip
        14'b1_0_0_0011_1_0_1_1001, // R9 pin low, pull released
        14'b1_1_0_0010_1_0_1_1001, // R9 pin high synced, still latched
        14'b1_1_0_0001_1_0_0_1001, // R9 armed, drive stays off
        14'b1_1_0_0001_1_1_1_1001  // R9 re-trip
    };

    task automatic check(input int req, input string what,
                         input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int lat;
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1, "drv_off in reset", drv_off, 1'b1);
        check(1, "pd_en in reset", pd_en, 1'b0);
        check(1, "fault in reset", fault_latched, 1'b0);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            oc_trip   = VECS[i][13];
            sd_pin_in = VECS[i][12];
            uv_flag   = VECS[i][11];
            repeat (int'(VECS[i][10:7])) @(posedge clk);
            @(negedge clk);
            check(int'(VECS[i][3:0]), "drv_off", drv_off, VECS[i][6]);
            check(int'(VECS[i][3:0]), "pd_en", pd_en, VECS[i][5]);
            check(int'(VECS[i][3:0]), "fault_latched", fault_latched, VECS[i][4]);
        end

        // R1 reset while pull-down active
        rst = 1'b1;
        oc_trip = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(1, "pd_en after mid-fault reset", pd_en, 1'b0);
        check(1, "fault after mid-fault reset", fault_latched, 1'b0);
        rst = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(1, "drv_off idle after reset", drv_off, 1'b0);

        // R10 kill latency in edges (200 MHz: 250 ns = 50 edges)
        oc_trip = 1'b1;
        lat = 0;
        while (!drv_off && lat < 60) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        check(10, "latency equals sync depth", lat == 2, 1'b1);
        check(10, "latency within budget", lat <= 50, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule